// File: doc/BRIEF.md
# Host Pixel Data Unpacker

During a host-to-screen blit, the host pushes 32-bit data words into the drawing engine. This block takes those words and produces the stream of pixels that the destination writer stores in the frame buffer. The host pads every source row with spare bytes up to the next word boundary. The block throws that padding away at the end of each row. It emits exactly the programmed number of pixels per row, for the programmed number of rows, at 8, 16 or 32 bits per pixel.

A command pulse loads the depth code and the rectangle size. Both dimensions are given as size minus one. The block then takes words through a valid/ready handshake on the host side and presents pixels through a valid/ready handshake on the pixel side. It holds one word at a time. It pushes back on the host whenever that word still has pixels to deliver. `busy_o` stays high from the command until the final pixel has been taken downstream.

Top module: `host_pix_unpack`

## Requirements
- R1: In reset, and directly after it, `busy_o` is 0, `pix_valid_o` is 0 and `wr_ready_o` is 1.
- R2: A `start_i` pulse while idle loads `depth_i`, `width_m1_i` and `height_m1_i`, and `busy_o` reads 1 on the next cycle. A `start_i` that arrives while `busy_o` is 1 has no effect, including in the cycle where the final pixel is accepted.
- R3: Within a host word, byte k occupies bits 8k+7:8k, and pixels are taken in ascending byte order. With depth code 0, each byte is one pixel, placed in `pix_data_o[7:0]`, and bits 31:8 are zero.
- R4: With depth code 1, a pixel is made of two consecutive bytes. The lower-addressed byte is the least-significant byte, the pixel occupies `pix_data_o[15:0]`, and bits 31:16 are zero.
- R5: With depth code 2, the whole word is one pixel. Depth code 3 behaves exactly like code 0.
- R6: A row spans ceil(W × B / 4) words, where W is `width_m1_i`+1 and B is the byte count per pixel. Bytes after the W-th pixel in the last word of a row are dropped, and the next row starts with the next word.
- R7: One command produces exactly (`width_m1_i`+1) × (`height_m1_i`+1) pixels, in row order.
- R8: While `pix_valid_o` is 1 and `pix_ready_i` is 0, `pix_valid_o` stays 1 and `pix_data_o` keeps its value on the next cycle.
- R9: While busy, `wr_ready_o` is 0 whenever the block still has an undelivered pixel (`pix_valid_o` is 1).
- R10: While idle, `wr_ready_o` is 1 and any word written is dropped: no pixel appears and `busy_o` stays 0.
- R11: `busy_o` falls on the cycle after the final pixel handshake, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command pulse that begins a transfer |
| depth_i | input | 2 | Depth code: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit, 3 = 8 bit |
| width_m1_i | input | DIM_W | Pixels per row minus one |
| height_m1_i | input | DIM_W | Rows minus one |
| wr_valid_i | input | 1 | Host data word valid |
| wr_data_i | input | 32 | Host data word |
| wr_ready_o | output | 1 | Block can accept a host word |
| pix_valid_o | output | 1 | Pixel output valid |
| pix_data_o | output | 32 | Pixel, zero-extended |
| pix_ready_i | input | 1 | Downstream accepts the pixel |
| busy_o | output | 1 | Transfer in progress |

## Verification
Two events can fall into the same cycle: acceptance of the final pixel of a transfer, and a new command pulse. The bench provokes this by raising `start_i` exactly when the final pixel is offered with `pix_ready_i` high. It then judges the result by requiring `busy_o` to drop on the next cycle, with no further pixel appearing. A cycle-level reference model pops expected pixels on each handshake. It also checks, on every clock, the busy level, the handshake hold and the host backpressure, for each depth and for widths that leave 0 to 3 padding bytes per row, under both free-running and randomly stalled handshakes on both sides.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
  localparam int WORD_W = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int SLOT_W = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    DEPTH_8   = 2'd0,
    DEPTH_16  = 2'd1,
    DEPTH_32  = 2'd2,
    DEPTH_RSV = 2'd3
  } depth_e;

  // index of the last pixel slot in a word for a given depth
  function automatic logic [SLOT_W-1:0] last_slot(depth_e d);
    case (d)
      DEPTH_16: last_slot = SLOT_W'(WORD_BYTES / 2 - 1);
      DEPTH_32: last_slot = '0;
      default:  last_slot = SLOT_W'(WORD_BYTES - 1);
    endcase
  endfunction
endpackage

// File: rtl/hpx_pix_sel.sv
module hpx_pix_sel
  import hpx_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  depth_e            depth_i,
  output logic [WORD_W-1:0] pix_o
);
  localparam int NHALF = WORD_W / 16;

  logic [7:0]  byte_l [WORD_BYTES];
  logic [15:0] half_l [NHALF];

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
    assign byte_l[b] = word_i[8*b +: 8];
  end
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign half_l[h] = word_i[16*h +: 16];
  end

  always_comb begin
    case (depth_i)
      DEPTH_16: pix_o = WORD_W'(half_l[slot_i[SLOT_W-2:0]]);
      DEPTH_32: pix_o = word_i;
      default:  pix_o = WORD_W'(byte_l[slot_i]);
    endcase
  end
endmodule

// File: rtl/hpx_span_cnt.sv
module hpx_span_cnt #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] max_i,
  output logic [W-1:0] cnt_o,
  output logic         at_max_o
);
  logic [W-1:0] cnt_q;

  assign at_max_o = (cnt_q == max_i);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= at_max_o ? '0 : cnt_q + 1'b1;
  end

  // R7: position never runs past the programmed extent
  a_r7_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> cnt_q <= max_i);
endmodule

// File: rtl/host_pix_unpack.sv
module host_pix_unpack
  import hpx_pkg::*;
#(
  parameter int DIM_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        depth_i,
  input  logic [DIM_W-1:0]  width_m1_i,
  input  logic [DIM_W-1:0]  height_m1_i,
  input  logic              wr_valid_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  output logic              pix_valid_o,
  output logic [WORD_W-1:0] pix_data_o,
  input  logic              pix_ready_i,
  output logic              busy_o
);
  logic              busy_q, buf_v_q;
  logic [WORD_W-1:0] buf_q;
  logic [SLOT_W-1:0] slot_q;
  depth_e            depth_q;
  logic [DIM_W-1:0]  wm1_q, hm1_q;
  logic [DIM_W-1:0]  col_cnt, row_cnt;
  logic              col_end, row_end;
  logic              start_go, fire, eol, eof, slot_end, word_take;

  assign start_go  = start_i && !busy_q;
  assign fire      = buf_v_q && pix_ready_i;
  assign eol       = col_end;
  assign eof       = eol && row_end;
  assign slot_end  = (slot_q == last_slot(depth_q));
  assign word_take = busy_q && !buf_v_q && wr_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      buf_v_q <= 1'b0;
      buf_q   <= '0;
      slot_q  <= '0;
      depth_q <= DEPTH_8;
      wm1_q   <= '0;
      hm1_q   <= '0;
    end else if (start_go) begin
      busy_q  <= 1'b1;
      buf_v_q <= 1'b0;
      slot_q  <= '0;
      depth_q <= depth_e'(depth_i);
      wm1_q   <= width_m1_i;
      hm1_q   <= height_m1_i;
    end else if (busy_q) begin
      if (word_take) begin
        buf_v_q <= 1'b1;
        buf_q   <= wr_data_i;
        slot_q  <= '0;
      end else if (fire) begin
        // row end drops any padding left in the word
        if (eol || slot_end) buf_v_q <= 1'b0;
        else                 slot_q  <= slot_q + 1'b1;
        if (eof) busy_q <= 1'b0;
      end
    end
  end

  hpx_span_cnt #(.W(DIM_W)) u_col (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_go),
    .step_i  (fire),
    .max_i   (wm1_q),
    .cnt_o   (col_cnt),
    .at_max_o(col_end)
  );

  hpx_span_cnt #(.W(DIM_W)) u_row (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_go),
    .step_i  (fire && eol),
    .max_i   (hm1_q),
    .cnt_o   (row_cnt),
    .at_max_o(row_end)
  );

  hpx_pix_sel u_sel (
    .word_i (buf_q),
    .slot_i (slot_q),
    .depth_i(depth_q),
    .pix_o  (pix_data_o)
  );

  assign pix_valid_o = buf_v_q;
  assign wr_ready_o  = !busy_q || !buf_v_q;
  assign busy_o      = busy_q;

  a_r2_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r8_pix_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_ready_i |=> pix_valid_o && $stable(pix_data_o));
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> wr_ready_o && !pix_valid_o);
  a_r11_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(pix_valid_o && pix_ready_i));
  a_r7_row_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> row_cnt <= hm1_q && col_cnt <= wm1_q);
endmodule

// File: tb/tb_host_pix_unpack.sv
module tb_host_pix_unpack;
  localparam int DIM_W = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_req = 1'b0, collide_start = 1'b0;
  logic        start_i;
  logic [1:0]  depth_r = '0;
  logic [DIM_W-1:0] wm1 = '0, hm1 = '0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready_o, pix_valid_o, busy_o;
  logic [31:0] pix_data_o;
  logic        pix_ready_i = 1'b1;

  int errors = 0, checks = 0, rem = 0;
  bit finished = 0, rdy_rnd = 0, collide_en = 0, collided = 0;
  bit hold_pend = 0;
  logic [31:0] hold_data = '0;
  logic [31:0] pixq[$];
  logic [31:0] wordq[$];

  assign start_i = start_req | collide_start;

  always #4 clk = ~clk;

  host_pix_unpack #(.DIM_W(DIM_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .depth_i(depth_r),
    .width_m1_i(wm1), .height_m1_i(hm1), .wr_valid_i(wr_valid),
    .wr_data_i(wr_data), .wr_ready_o(wr_ready_o), .pix_valid_o(pix_valid_o),
    .pix_data_o(pix_data_o), .pix_ready_i(pix_ready_i), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  always @(posedge clk) begin
    #2 pix_ready_i = rdy_rnd ? (($urandom % 3) != 0) : 1'b1;
  end

  // reference model, evaluated between edges
  always @(negedge clk) begin
    if (rst_ni) begin
      chk(busy_o == (rem != 0), "R11 busy level", 32'(busy_o), 32'(rem != 0));
      if (!busy_o)
        chk(wr_ready_o && !pix_valid_o, "R10 idle outputs",
            {30'd0, wr_ready_o, pix_valid_o}, 32'h2);
      if (pix_valid_o)
        chk(!wr_ready_o, "R9 backpressure", 32'(wr_ready_o), 32'd0);
      if (hold_pend)
        chk(pix_valid_o && pix_data_o == hold_data, "R8 hold", pix_data_o, hold_data);
      collide_start = collide_en && rem == 1 && pix_valid_o && pix_ready_i;
      if (collide_start) collided = 1;
      if (pix_valid_o && pix_ready_i) begin
        if (pixq.size() == 0) begin
          chk(0, "R7 extra pixel", pix_data_o, 32'hx);
        end else begin
          chk(pix_data_o == pixq[0], "R3 R4 R5 R6 pixel value", pix_data_o, pixq[0]);
          void'(pixq.pop_front());
        end
        if (rem > 0) rem--;
      end
      if ((start_req || collide_start) && !busy_o)
        rem = (int'(wm1) + 1) * (int'(hm1) + 1);
      hold_pend = pix_valid_o && !pix_ready_i;
      hold_data = pix_data_o;
    end
  end

  task automatic run_frame(input int dep, input int w, input int h,
                           input bit rnd, input bit collide);
    int bpp;
    bit ok;
    bpp = (dep == 1) ? 2 : (dep == 2) ? 4 : 1;
    for (int r = 0; r < h; r++) begin
      logic [7:0] rb[$];
      for (int p = 0; p < w; p++) begin
        logic [31:0] v;
        v = $urandom;
        if (bpp == 1) v = v & 32'hFF;
        if (bpp == 2) v = v & 32'hFFFF;
        pixq.push_back(v);
        for (int k = 0; k < bpp; k++) rb.push_back(8'(v >> (8 * k)));
      end
      while (rb.size() % 4 != 0) rb.push_back(8'hA5);
      for (int i = 0; i < rb.size(); i += 4)
        wordq.push_back({rb[i+3], rb[i+2], rb[i+1], rb[i]});
    end
    rdy_rnd = rnd;
    collide_en = collide;
    collided = 0;
    step();
    start_req = 1'b1;
    depth_r = 2'(dep);
    wm1 = DIM_W'(w - 1);
    hm1 = DIM_W'(h - 1);
    step();
    start_req = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b1, "R2 busy after start", 32'(busy_o), 32'd1);
    step();
    while (wordq.size() != 0) begin
      wr_valid = rnd ? (($urandom % 4) != 0) : 1'b1;
      wr_data = wordq[0];
      @(negedge clk);
      ok = wr_valid && wr_ready_o;
      step();
      if (ok) void'(wordq.pop_front());
    end
    wr_valid = 1'b0;
    while (rem != 0) step();
    step();
    @(negedge clk);
    chk(pixq.size() == 0, "R7 pixel count", 32'(pixq.size()), 32'd0);
    chk(!busy_o, "R11 idle after frame", 32'(busy_o), 32'd0);
    if (collide) begin
      chk(collided, "R2 collision provoked", 32'(collided), 32'd1);
      chk(!busy_o && !pix_valid_o, "R2 start on final pixel ignored",
          {30'd0, busy_o, pix_valid_o}, 32'd0);
    end
    collide_en = 0;
    rdy_rnd = 0;
    step();
  endtask

  task automatic idle_words();
    for (int i = 0; i < 3; i++) begin
      wr_valid = 1'b1;
      wr_data = 32'hDEAD_0000 + 32'(i);
      @(negedge clk);
      chk(wr_ready_o, "R10 ready while idle", 32'(wr_ready_o), 32'd1);
      step();
    end
    wr_valid = 1'b0;
    step();
    @(negedge clk);
    chk(!busy_o && !pix_valid_o, "R10 idle words dropped",
        {30'd0, busy_o, pix_valid_o}, 32'd0);
    step();
  endtask

  initial begin
    #3;
    chk(!busy_o && !pix_valid_o && wr_ready_o, "R1 reset state",
        {29'd0, busy_o, pix_valid_o, wr_ready_o}, 32'd1);
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !pix_valid_o && wr_ready_o, "R1 after reset",
        {29'd0, busy_o, pix_valid_o, wr_ready_o}, 32'd1);
    step();
    idle_words();
    run_frame(0, 5, 3, 0, 0);   // R3 R6: 3 pad bytes per row
    run_frame(1, 3, 2, 1, 0);   // R4 R6: 2 pad bytes per row
    run_frame(2, 4, 2, 1, 0);   // R5
    run_frame(3, 2, 2, 0, 0);   // R5 reserved code as 8 bit
    run_frame(0, 4, 1, 1, 0);   // R6 no padding
    run_frame(1, 1, 1, 0, 0);   // R6 single pixel, half word pad
    run_frame(0, 7, 4, 1, 0);   // R6 1 pad byte per row, stalls
    run_frame(0, 3, 2, 0, 1);   // R2 collision with final pixel
    run_frame(2, 2, 3, 0, 1);   // R2 collision at 32 bit
    idle_words();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule